// File: doc/BRIEF.md
# DAC Clear-State and Fault Controller

This block sits next to the data register of a 16-bit DAC and decides which code the converter actually sees. An active-low clear pin can push the DAC into a latched clear state. While the block is in that state, the code is forced either to a programmed clear value or to a zero-state code that depends on the output mode. A control bit picks one of two policies for leaving the clear state. The first releases the state as soon as the pin goes high again. The second holds it until the pin is high and software also acts: it writes a DAC code, strobes the load line, or drops the hold bit.

The same block drives a registered, active-low fault flag. The flag reports two things, each under its own enable:
- the clear state;
- raw output-fault indications from the analog stage, one for a voltage-output short and one for a current-output open or dropout.

All control bits arrive as levels from a register file outside the block. That register file returns the hold bit to 0 on power-on reset. The block also owns the DAC data register. Writes to address 0x04 (DAC register) or 0x05 (load-DAC register) update it.

Top module: `dac_clear_ctrl`

## Requirements
- R1: With `pin_disable` = 0, a low level on `clr_pin_n` puts the block in the clear state. The pin passes through a two-stage synchronizer, so after the pin falls `clear_status` reads 1 on the third rising clock edge.
- R2: With `pin_disable` = 1, `clr_pin_n` has no effect: `clear_status` stays 0 and `dac_code` keeps the DAC register value.
- R3: In the clear state, `dac_code` equals `clear_value` when `clr_src_sel` = 1 and `zero_code` when `clr_src_sel` = 0. A change of the selection takes effect one clock later.
- R4: With `hold_clear` = 1, the clear state persists until the synchronized pin is high and, in the same cycle, either a write to address 0x04 or 0x05 occurs or `load_n` is low. Pin-high alone, writes while the pin is low, and writes to other addresses do not exit.
- R5: With `hold_clear` = 1 and the synchronized pin high, changing `hold_clear` to 0 ends the clear state on the next clock edge.
- R6: With `hold_clear` = 0, the clear state ends when the synchronized pin is high or when `pin_disable` is 1. After the pin rises, `clear_status` returns to 0 on the third rising edge.
- R7: While `rst_n` is low at a clock edge, the following values are set: `clear_status` = 0, `dac_code` = 0, `fault_n` = 1, the DAC register = 0.
- R8: A write (`wr_en` = 1) to address 0x04 or 0x05 stores `wr_data` in the DAC register, including during the clear state. Writes to other addresses are ignored. Outside the clear state `dac_code` follows the register one clock after the write. Leaving the clear state restores the register value, which is the newly written value when the exit was caused by a write.
- R9: `fault_n` is 0 one clock after a cycle in which `flag_clear_en` = 1 and the block is in the clear state.
- R10: `fault_n` is 0 one clock after a cycle in which `fault_en` = 1 and either `fault_v_raw` or `fault_i_raw` is 1. Otherwise, and outside R9, `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| clr_pin_n | input | 1 | Asynchronous active-low clear pin |
| load_n | input | 1 | Synchronous active-low load strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Register write address |
| wr_data | input | CODE_W (16) | Register write data |
| clr_src_sel | input | 1 | 1: clear forces clear_value, 0: forces zero_code |
| pin_disable | input | 1 | 1: clear pin ignored |
| hold_clear | input | 1 | 1: clear state needs a software action to exit |
| fault_en | input | 1 | Report output faults on fault_n |
| flag_clear_en | input | 1 | Report clear state on fault_n |
| clear_value | input | CODE_W (16) | Programmed clear code |
| zero_code | input | CODE_W (16) | Mode-dependent zero-state code |
| fault_v_raw | input | 1 | Voltage-output short indication |
| fault_i_raw | input | 1 | Current-output open/dropout indication |
| dac_code | output | CODE_W (16) | Effective code driven to the DAC |
| clear_status | output | 1 | 1 while in the clear state |
| fault_n | output | 1 | Registered active-low fault flag |

## Verification
The bench builds the block with its defaults: 16-bit codes, 8-bit addresses, DAC register at 0x04, load-DAC register at 0x05, and two synchronizer stages. The full code width lets random writes reach both the top and bottom bytes of the code. The two-stage synchronizer makes entry and pin-driven exit land exactly on the third edge, which the directed sequences check. Addresses 0x03 and 0x06 sit on either side of the two code addresses, so random writes probe both neighbours of the decode.

// File: rtl/dcc_pkg.sv
// Shared types for the DAC clear controller.
// Assumes control bits are levels held stable by an external register file.
package dcc_pkg;

    typedef struct packed {
        logic src_sel;     // 1: clear value, 0: zero code
        logic pin_dis;     // 1: clear pin ignored
        logic hold;        // 1: software action needed to exit
        logic fault_en;    // report analog faults
        logic flag_en;     // report clear state
    } dcc_ctl_t;

endpackage

// File: rtl/dcc_sync.sv
// Multi-stage synchronizer for an asynchronous active-low pin.
// Assumes the pin idles high, so every stage resets to 1.
module dcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage: plain register.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d_async;
            end
        end else begin : g_many
            // Shift the pin through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dcc_clear_fsm.sv
// Latched clear-state tracker with two exit policies.
// Entry: synchronized pin low while the pin is enabled (entry wins over exit).
// Exit (hold=0): pin high or pin disabled. Exit (hold=1): pin high plus a
// code write or load strobe. clr_next is the state the next edge will hold.
module dcc_clear_fsm
    import dcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_sync,
    input  dcc_ctl_t ctl,
    input  logic     code_wr,
    input  logic     load_n,
    output logic     clr_next,
    output logic     clr_state
);
    logic enter_c;
    logic exit_c;

    // Decide entry and exit conditions for this cycle.
    always_comb begin
        enter_c = !ctl.pin_dis && !pin_sync;
        if (ctl.hold)
            exit_c = pin_sync && (code_wr || !load_n);
        else
            exit_c = pin_sync || ctl.pin_dis;
        clr_next = enter_c || (clr_state && !exit_c);
    end

    // Hold the latched clear state.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_state <= 1'b0;
        else        clr_state <= clr_next;
    end
endmodule

// File: rtl/dcc_code_path.sv
// DAC data register and effective-code selection.
// Assumes writes to either code address load the same register.
module dcc_code_path #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              clr_next,
    input  logic              src_sel,
    input  logic [CODE_W-1:0] clear_value,
    input  logic [CODE_W-1:0] zero_code,
    output logic [CODE_W-1:0] dac_code
);
    logic [CODE_W-1:0] data_reg;
    logic [CODE_W-1:0] data_next;
    logic [CODE_W-1:0] code_next;

    // Next register value and the code it implies.
    always_comb begin
        data_next = code_wr ? wr_data : data_reg;
        if (clr_next)
            code_next = src_sel ? clear_value : zero_code;
        else
            code_next = data_next;
    end

    // Register the data word and the effective code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_reg <= '0;
            dac_code <= '0;
        end else begin
            data_reg <= data_next;
            dac_code <= code_next;
        end
    end
endmodule

// File: rtl/dcc_fault.sv
// Registered active-low fault flag merging clear-state and analog faults.
// Assumes raw fault levels are already stable in the clock domain.
module dcc_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_next,
    input  logic flag_en,
    input  logic fault_en,
    input  logic fv_raw,
    input  logic fi_raw,
    output logic fault_n
);
    logic active_c;

    // Combine both fault sources under their enables.
    always_comb begin
        active_c = (flag_en && clr_next) || (fault_en && (fv_raw || fi_raw));
    end

    // Register the released-high output.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_n <= 1'b1;
        else        fault_n <= !active_c;
    end
endmodule

// File: rtl/dac_clear_ctrl.sv
// Top: clear-state and fault control beside a DAC data register.
// Assumes synchronous reset at power-on and level control bits.
module dac_clear_ctrl
    import dcc_pkg::*;
#(
    parameter int          CODE_W     = 16,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  DAC_ADDR   = 8'h04,
    parameter logic [7:0]  LOAD_ADDR  = 8'h05,
    parameter int          SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_pin_n,
    input  logic              load_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              clr_src_sel,
    input  logic              pin_disable,
    input  logic              hold_clear,
    input  logic              fault_en,
    input  logic              flag_clear_en,
    input  logic [CODE_W-1:0] clear_value,
    input  logic [CODE_W-1:0] zero_code,
    input  logic              fault_v_raw,
    input  logic              fault_i_raw,
    output logic [CODE_W-1:0] dac_code,
    output logic              clear_status,
    output logic              fault_n
);
    localparam logic [ADDR_W-1:0] A_DAC  = ADDR_W'(DAC_ADDR);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(LOAD_ADDR);

    dcc_ctl_t ctl;
    logic     pin_sync;
    logic     code_wr;
    logic     clr_next;

    // Gather control bits and decode code writes.
    always_comb begin
        ctl.src_sel  = clr_src_sel;
        ctl.pin_dis  = pin_disable;
        ctl.hold     = hold_clear;
        ctl.fault_en = fault_en;
        ctl.flag_en  = flag_clear_en;
        code_wr      = wr_en && ((wr_addr == A_DAC) || (wr_addr == A_LOAD));
    end

    dcc_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (clr_pin_n),
        .q_sync  (pin_sync)
    );

    dcc_clear_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_sync  (pin_sync),
        .ctl       (ctl),
        .code_wr   (code_wr),
        .load_n    (load_n),
        .clr_next  (clr_next),
        .clr_state (clear_status)
    );

    dcc_code_path #(.CODE_W(CODE_W)) code_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_wr     (code_wr),
        .wr_data     (wr_data),
        .clr_next    (clr_next),
        .src_sel     (ctl.src_sel),
        .clear_value (clear_value),
        .zero_code   (zero_code),
        .dac_code    (dac_code)
    );

    dcc_fault fault_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_next (clr_next),
        .flag_en  (ctl.flag_en),
        .fault_en (ctl.fault_en),
        .fv_raw   (fault_v_raw),
        .fi_raw   (fault_i_raw),
        .fault_n  (fault_n)
    );
endmodule

// File: rtl/dcc_checker.sv
// Property checker for dac_clear_ctrl, attached by bind.
module dcc_checker #(
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_sync,
    input logic              pin_disable,
    input logic              hold_clear,
    input logic              clr_src_sel,
    input logic              fault_en,
    input logic              flag_clear_en,
    input logic              fault_v_raw,
    input logic              fault_i_raw,
    input logic [CODE_W-1:0] clear_value,
    input logic [CODE_W-1:0] zero_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              clear_status,
    input logic              fault_n
);
    logic seen;

    // Mark that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_disable && !pin_sync) |=> clear_status);

    a_r2_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_disable && !clear_status) |=> !clear_status);

    a_r3_forced_code: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && clear_status) |->
            dac_code == ($past(clr_src_sel) ? $past(clear_value) : $past(zero_code)));

    a_r4_hold_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_status && hold_clear && !pin_sync) |=> clear_status);

    a_r6_exit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_status && !hold_clear && pin_disable) |=> !clear_status);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && clear_status && $past(flag_clear_en)) |-> !fault_n);

    a_r10_flag_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(fault_en && (fault_v_raw || fault_i_raw))) |-> !fault_n);
endmodule

bind dac_clear_ctrl dcc_checker #(.CODE_W(CODE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_sync      (pin_sync),
    .pin_disable   (pin_disable),
    .hold_clear    (hold_clear),
    .clr_src_sel   (clr_src_sel),
    .fault_en      (fault_en),
    .flag_clear_en (flag_clear_en),
    .fault_v_raw   (fault_v_raw),
    .fault_i_raw   (fault_i_raw),
    .clear_value   (clear_value),
    .zero_code     (zero_code),
    .dac_code      (dac_code),
    .clear_status  (clear_status),
    .fault_n       (fault_n)
);

// File: tb/dac_clear_ctrl_tb_top.sv
// Testbench: directed clear-state sequences plus seeded random code writes.
module dac_clear_ctrl_tb_top;
    localparam int CW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clr_pin_n, load_n, wr_en;
    logic [AW-1:0] wr_addr;
    logic [CW-1:0] wr_data;
    logic          clr_src_sel, pin_disable, hold_clear, fault_en, flag_clear_en;
    logic [CW-1:0] clear_value, zero_code;
    logic          fault_v_raw, fault_i_raw;
    logic [CW-1:0] dac_code;
    logic          clear_status, fault_n;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] model_reg;

    always #10 clk = ~clk;

    dac_clear_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .clr_pin_n(clr_pin_n), .load_n(load_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_src_sel(clr_src_sel), .pin_disable(pin_disable),
        .hold_clear(hold_clear), .fault_en(fault_en),
        .flag_clear_en(flag_clear_en), .clear_value(clear_value),
        .zero_code(zero_code), .fault_v_raw(fault_v_raw),
        .fault_i_raw(fault_i_raw), .dac_code(dac_code),
        .clear_status(clear_status), .fault_n(fault_n)
    );

    function automatic logic exp_fault_n(input logic fen, input logic fv,
                                         input logic fi, input logic flg,
                                         input logic clr);
        return !((fen && (fv || fi)) || (flg && clr));
    endfunction

    function automatic logic is_code_addr(input logic [AW-1:0] a);
        return (a == 8'h04) || (a == 8'h05);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge, then settle away from the edge.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write(input logic [AW-1:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
        if (is_code_addr(a)) model_reg = d;
    endtask

    initial begin
        #4_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; clr_pin_n = 1'b1; load_n = 1'b1; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; clr_src_sel = 1'b1; pin_disable = 1'b0;
        hold_clear = 1'b0; fault_en = 1'b0; flag_clear_en = 1'b0;
        clear_value = 16'h8000; zero_code = 16'h0CCC;
        fault_v_raw = 1'b0; fault_i_raw = 1'b0; model_reg = '0;
        tick(3);
        // R7 reset state
        chk("R7 status", 32'(clear_status), 0);
        chk("R7 code", 32'(dac_code), 0);
        chk("R7 fault_n", 32'(fault_n), 1);
        rst_n = 1'b1;
        tick();

        // R8 write to DAC register address
        write(8'h04, 16'hA5A5);
        chk("R8 code after write", 32'(dac_code), 32'hA5A5);

        // R2 pin ignored while disabled
        pin_disable = 1'b1; clr_pin_n = 1'b0;
        tick(4);
        chk("R2 status", 32'(clear_status), 0);
        chk("R2 code", 32'(dac_code), 32'hA5A5);
        clr_pin_n = 1'b1; tick(3);
        pin_disable = 1'b0;

        // R1/R3/R9 entry, software-clear code, clear flag
        flag_clear_en = 1'b1; clr_pin_n = 1'b0;
        tick(2);
        chk("R1 not yet at edge 2", 32'(clear_status), 0);
        tick();
        chk("R1 status at edge 3", 32'(clear_status), 1);
        chk("R3 clear value", 32'(dac_code), 32'h8000);
        chk("R9 fault_n", 32'(fault_n), 0);
        clr_src_sel = 1'b0; tick();
        chk("R3 zero code", 32'(dac_code), 32'h0CCC);

        // R6 exit on pin high, R8 restore
        clr_pin_n = 1'b1;
        tick(2);
        chk("R6 still clear at edge 2", 32'(clear_status), 1);
        tick();
        chk("R6 exit on pin high", 32'(clear_status), 0);
        chk("R8 restored code", 32'(dac_code), 32'hA5A5);
        chk("R9 flag released", 32'(fault_n), 1);

        // R4 hold policy: pin high alone and foreign address do not exit
        hold_clear = 1'b1; clr_pin_n = 1'b0; tick(3);
        write(8'h04, 16'h1234);
        chk("R4 write with pin low keeps clear", 32'(clear_status), 1);
        chk("R8 write in clear keeps forced code", 32'(dac_code), 32'h0CCC);
        clr_pin_n = 1'b1; tick(4);
        chk("R4 pin high alone", 32'(clear_status), 1);
        write(8'h06, 16'hFFFF);
        chk("R4 other address", 32'(clear_status), 1);
        write(8'h05, 16'hBEEF);
        chk("R4 exit by load-DAC write", 32'(clear_status), 0);
        chk("R8 code is new write", 32'(dac_code), 32'hBEEF);

        // R4 exit by load strobe
        clr_pin_n = 1'b0; tick(3); clr_pin_n = 1'b1; tick(3);
        chk("R4 held before strobe", 32'(clear_status), 1);
        load_n = 1'b0; tick(); load_n = 1'b1;
        chk("R4 exit by load strobe", 32'(clear_status), 0);
        chk("R8 code restored after strobe", 32'(dac_code), 32'hBEEF);

        // R5 exit by clearing the hold bit
        clr_pin_n = 1'b0; tick(3); clr_pin_n = 1'b1; tick(3);
        hold_clear = 1'b0; tick();
        chk("R5 exit on hold cleared", 32'(clear_status), 0);

        // R6 exit by disabling the pin while it is still low
        clr_pin_n = 1'b0; tick(3);
        chk("R6 entered", 32'(clear_status), 1);
        pin_disable = 1'b1; tick();
        chk("R6 exit on disable", 32'(clear_status), 0);
        clr_pin_n = 1'b1; tick(3); pin_disable = 1'b0;

        // R10 analog fault masked when disabled
        flag_clear_en = 1'b0; fault_v_raw = 1'b1; tick();
        chk("R10 masked", 32'(fault_n), 1);
        fault_en = 1'b1; tick();
        chk("R10 voltage fault", 32'(fault_n), 0);
        fault_v_raw = 1'b0; fault_i_raw = 1'b1; tick();
        chk("R10 current fault", 32'(fault_n), 0);
        fault_i_raw = 1'b0; tick();
        chk("R10 released", 32'(fault_n), 1);

        // Random phase: code writes (R8) and fault merging (R10), pin idle
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic fen, fv, fi, we;
            a   = AW'(3 + ($urandom() % 4));
            we  = 1'($urandom());
            fen = 1'($urandom()); fv = 1'($urandom()); fi = 1'($urandom());
            wr_en = we; wr_addr = a; wr_data = CW'($urandom());
            fault_en = fen; fault_v_raw = fv; fault_i_raw = fi;
            flag_clear_en = 1'($urandom()); load_n = 1'($urandom());
            hold_clear = 1'($urandom()); pin_disable = 1'($urandom());
            if (we && is_code_addr(a)) model_reg = wr_data;
            tick();
            chk("R8 random code", 32'(dac_code), 32'(model_reg));
            chk("R10 random fault", 32'(fault_n), 32'(exp_fault_n(fen, fv, fi, 1'b0, 1'b0)));
        end
        wr_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule